// File: doc/BRIEF.md
# Multi-Master System Bus Arbiter

This block couples one processor to a shared multi-master system bus. It watches the processor's 3-bit bus status code and decides when the shared bus is wanted and when it may be given away. It joins a bus-wide arbitration scheme through several signals:

- an active-low request output;
- a priority input and a priority output, which can be chained from master to master;
- an open-drain busy line, modelled as a sense input plus a drive-enable output;
- an open-drain common request line, modelled the same way.

While the bus is not owned, an active-low address-enable output keeps the local address latches and command drivers off the shared bus.

The status code is first registered on the processor clock. It then crosses into the bus-clock domain through a synchronizer. All arbitration decisions are taken on falling edges of the bus clock. Two mode inputs pick the configuration:

- single bus;
- an I/O-bus configuration, in which only memory commands need the shared bus;
- a resident-bus configuration, in which an address-decode select input chooses between the shared bus and a private bus;
- both of the above combined.

Surrender is lazy. An owner keeps the bus until it halts, until a higher-priority master takes the priority input away, or until a lower-priority master asks through the common request line while the owner's mode allows it. Two lock inputs hold off surrender. An any-request mode input lets common requests also take the bus at the end of each transfer.

Top module: `mm_bus_arbiter`

## Requirements
- R1: Status codes: 111 is idle, 011 is halt, 000/001/010 are I/O or interrupt, and 100/101/110 are memory. In single-bus mode (iobus_mode_ni=1, resbus_mode_i=0), any I/O or memory code raises a request (req_no=0). Idle and halt do not.
- R2: In I/O-bus mode (iobus_mode_ni=0), only memory codes raise a request. An owner that sees an I/O or idle code gives the bus up when cbrq_ni is low.
- R3: When resbus_mode_i=1, a request needs sys_sel_i=1 together with a code that the mode would otherwise request. While sys_sel_i=0, an owner gives the bus up when cbrq_ni is low. In single-bus and I/O-bus modes, sys_sel_i has no effect.
- R4: A requesting arbiter becomes owner (busy_drive_o=1) on a falling bus-clock edge where prio_ni=0 and busy_ni=1. Otherwise it keeps requesting.
- R5: Once it owns the bus, the arbiter keeps it while prio_ni=0 and cbrq_ni=1, whatever non-halt status follows.
- R6: An owner surrenders on a halt code or when prio_ni goes high. After any surrender, req_no stays high for at least one bus-clock cycle.
- R7: In single-bus mode, an owner that sees idle status with cbrq_ni=0 surrenders.
- R8: With any_req_i=1 and cbrq_ni=0, an owner also surrenders when the synchronized status leaves a memory or I/O code for any other code. With any_req_i=0, that change alone does not cause surrender.
- R9: While lock_ni=0, the arbiter never surrenders. While crq_lock_ni=0, surrender caused by cbrq_ni is blocked, but halt and priority loss still cause surrender.
- R10: cbrq_drive_o is 1 only while the arbiter requests without owning the bus and prio_ni=1. An owner never drives it.
- R11: While not requesting, prio_no follows prio_ni. While requesting or owning, prio_no is 1.
- R12: aen_no goes low on the same falling bus-clock edge that makes the arbiter owner. After ownership is lost, aen_no goes high on the next rising processor-clock edge.
- R13: rst_ni=0 asynchronously clears ownership: busy_drive_o=0, cbrq_drive_o=0, req_no=1, aen_no=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Processor clock; status capture and address-enable release |
| bclk_i | input | 1 | Bus clock; arbitration acts on its falling edge |
| rst_ni | input | 1 | Active-low asynchronous initialization |
| status_i | input | 3 | Processor bus status code |
| iobus_mode_ni | input | 1 | Low selects the I/O-bus configuration |
| resbus_mode_i | input | 1 | High selects the resident-bus configuration |
| sys_sel_i | input | 1 | Address-decode select: high means the shared bus is addressed |
| any_req_i | input | 1 | High lets common requests take the bus at each transfer end |
| lock_ni | input | 1 | Low blocks every surrender |
| crq_lock_ni | input | 1 | Low blocks surrender to common requests |
| prio_ni | input | 1 | Active-low priority granted to this arbiter |
| prio_no | output | 1 | Active-low priority passed to the next lower arbiter |
| req_no | output | 1 | Active-low bus request |
| busy_ni | input | 1 | Sensed level of the shared busy line (low = bus taken) |
| busy_drive_o | output | 1 | Pull the busy line low |
| cbrq_ni | input | 1 | Sensed level of the common request line |
| cbrq_drive_o | output | 1 | Pull the common request line low |
| aen_no | output | 1 | Active-low address enable for local bus drivers |

## Verification
The assertions assume the following about the inputs:

- Mode inputs change only while the status code is being replaced.
- Priority, busy and common-request inputs are stable around each falling bus-clock edge.
- The two lock inputs reach the state machine only through the synchronizer, so the properties for them are stated on synchronized values.

The stimulus keeps within these limits. It changes inputs one nanosecond after a falling bus-clock edge, away from both clocks' active edges. It then holds each pattern for ten bus cycles, longer than the capture, synchronizer and surrender-then-reacquire chain. Where a lock must be in force before the event it guards, it is applied one pattern earlier.

// File: rtl/mmb_pkg.sv
package mmb_pkg;
  localparam int unsigned STATUS_W = 3;
  localparam logic [STATUS_W-1:0] CODE_IDLE = 3'b111;
  localparam logic [STATUS_W-1:0] CODE_HALT = 3'b011;

  typedef enum logic [1:0] {
    ARB_IDLE,
    ARB_REQ,
    ARB_OWN
  } arb_state_e;

  typedef struct packed {
    logic need;     // shared bus wanted now
    logic give_ok;  // mode window in which a common request may take the bus
    logic halt;
    logic active;   // I/O or memory command code
  } stat_dec_t;
endpackage

// File: rtl/mmb_sync.sv
module mmb_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[LAST];
endmodule

// File: rtl/mmb_decode.sv
module mmb_decode
  import mmb_pkg::*;
(
  input  logic [STATUS_W-1:0] status_i,
  input  logic                sel_i,
  input  logic                iob_mode_ni,
  input  logic                res_mode_i,
  output stat_dec_t           dec_o
);
  logic is_idle, is_halt, is_io, is_mem;
  logic base_need, base_give;

  always_comb begin
    is_idle = (status_i == CODE_IDLE);
    is_halt = (status_i == CODE_HALT);
    is_io   = !status_i[STATUS_W-1] && !is_halt;
    is_mem  = status_i[STATUS_W-1] && !is_idle;

    base_need = iob_mode_ni ? (is_io || is_mem) : is_mem;
    base_give = iob_mode_ni ? is_idle : (is_io || is_idle);

    dec_o.need    = res_mode_i ? (base_need && sel_i) : base_need;
    dec_o.give_ok = res_mode_i ? (base_give || !sel_i) : base_give;
    dec_o.halt    = is_halt;
    dec_o.active  = is_io || is_mem;
  end
endmodule

// File: rtl/mmb_bus_fsm.sv
module mmb_bus_fsm
  import mmb_pkg::*;
(
  input  logic                clk_i,      // falling bus-clock edge as rising
  input  logic                rst_ni,
  input  stat_dec_t           dec_i,
  input  logic [STATUS_W-1:0] status_i,
  input  logic                any_req_i,
  input  logic                lock_ni,
  input  logic                crq_lock_ni,
  input  logic                prio_ni,
  input  logic                busy_ni,
  input  logic                cbrq_ni,
  output logic                own_o,
  output logic                req_no,
  output logic                prio_no,
  output logic                cbrq_drive_o
);
  arb_state_e          state_q, state_d;
  logic [STATUS_W-1:0] prev_code_q;
  logic                prev_active_q;
  logic                cycle_end, cbrq_give, surrender;

  always_comb begin
    cycle_end = prev_active_q && (status_i != prev_code_q);
    cbrq_give = !cbrq_ni && crq_lock_ni && (dec_i.give_ok || (any_req_i && cycle_end));
    surrender = lock_ni && (dec_i.halt || prio_ni || cbrq_give);

    state_d = state_q;
    unique case (state_q)
      ARB_IDLE: if (dec_i.need) state_d = ARB_REQ;
      ARB_REQ: begin
        if (!dec_i.need) state_d = ARB_IDLE;
        else if (!prio_ni && busy_ni) state_d = ARB_OWN;
      end
      ARB_OWN: if (surrender) state_d = ARB_IDLE;
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ARB_IDLE;
      prev_code_q   <= CODE_IDLE;
      prev_active_q <= 1'b0;
    end else begin
      state_q       <= state_d;
      prev_code_q   <= status_i;
      prev_active_q <= dec_i.active;
    end
  end

  assign own_o        = (state_q == ARB_OWN);
  assign req_no       = (state_q == ARB_IDLE);
  assign prio_no      = (state_q == ARB_IDLE) ? prio_ni : 1'b1;
  assign cbrq_drive_o = (state_q == ARB_REQ) && prio_ni;
endmodule

// File: rtl/mmb_aen.sv
module mmb_aen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic own_i,
  output logic aen_no
);
  logic hold_q;

  // release only on a processor-clock edge after ownership ends
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= own_i;
  end

  assign aen_no = !(own_i || hold_q);
endmodule

// File: rtl/mm_bus_arbiter.sv
module mm_bus_arbiter
  import mmb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                bclk_i,
  input  logic                rst_ni,
  input  logic [STATUS_W-1:0] status_i,
  input  logic                iobus_mode_ni,
  input  logic                resbus_mode_i,
  input  logic                sys_sel_i,
  input  logic                any_req_i,
  input  logic                lock_ni,
  input  logic                crq_lock_ni,
  input  logic                prio_ni,
  output logic                prio_no,
  output logic                req_no,
  input  logic                busy_ni,
  output logic                busy_drive_o,
  input  logic                cbrq_ni,
  output logic                cbrq_drive_o,
  output logic                aen_no
);
  localparam int unsigned XW = STATUS_W + 3;
  localparam logic [XW-1:0] X_RST = {CODE_IDLE, 1'b0, 1'b1, 1'b1};

  logic                bclk_fall;
  logic [STATUS_W-1:0] stat_cap_q;
  logic                sel_cap_q;
  logic [XW-1:0]       xing_s;
  logic [STATUS_W-1:0] status_s;
  logic                sel_s, lock_s_n, crql_s_n, own;
  stat_dec_t           dec;

  assign bclk_fall = ~bclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_cap_q <= CODE_IDLE;
      sel_cap_q  <= 1'b0;
    end else begin
      stat_cap_q <= status_i;
      sel_cap_q  <= sys_sel_i;
    end
  end

  mmb_sync #(.WIDTH(XW), .STAGES(SYNC_STAGES), .RST_VAL(X_RST)) i_sync (
    .clk_i  (bclk_fall),
    .rst_ni (rst_ni),
    .d_i    ({stat_cap_q, sel_cap_q, lock_ni, crq_lock_ni}),
    .q_o    (xing_s)
  );

  assign {status_s, sel_s, lock_s_n, crql_s_n} = xing_s;

  mmb_decode i_decode (
    .status_i    (status_s),
    .sel_i       (sel_s),
    .iob_mode_ni (iobus_mode_ni),
    .res_mode_i  (resbus_mode_i),
    .dec_o       (dec)
  );

  mmb_bus_fsm i_fsm (
    .clk_i        (bclk_fall),
    .rst_ni       (rst_ni),
    .dec_i        (dec),
    .status_i     (status_s),
    .any_req_i    (any_req_i),
    .lock_ni      (lock_s_n),
    .crq_lock_ni  (crql_s_n),
    .prio_ni      (prio_ni),
    .busy_ni      (busy_ni),
    .cbrq_ni      (cbrq_ni),
    .own_o        (own),
    .req_no       (req_no),
    .prio_no      (prio_no),
    .cbrq_drive_o (cbrq_drive_o)
  );

  mmb_aen i_aen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .own_i  (own),
    .aen_no (aen_no)
  );

  assign busy_drive_o = own;
endmodule

// File: rtl/mmb_arbiter_chk.sv
module mmb_arbiter_chk (
  input logic bclk_i,
  input logic rst_ni,
  input logic prio_ni,
  input logic busy_ni,
  input logic prio_no,
  input logic req_no,
  input logic busy_drive_o,
  input logic cbrq_drive_o,
  input logic aen_no,
  input logic lock_s_n
);
  // R4
  grant_needs_priority_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    $rose(busy_drive_o) |-> $past(!prio_ni && busy_ni && !req_no));

  // R6
  release_gap_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    $fell(busy_drive_o) |-> (req_no && (prio_no == prio_ni)));

  // R9
  lock_holds_bus_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    $fell(busy_drive_o) |-> $past(lock_s_n));

  // R10
  cbrq_waiter_only_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    cbrq_drive_o |-> (prio_ni && !req_no && !busy_drive_o));

  // R11
  prio_pass_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    req_no |-> (prio_no == prio_ni));

  // R11
  prio_block_chk: assert property (@(negedge bclk_i) disable iff (!rst_ni)
    !req_no |-> prio_no);

  // R13
  init_release_chk: assert property (@(negedge bclk_i)
    !rst_ni |-> (req_no && !busy_drive_o && !cbrq_drive_o && aen_no));
endmodule

bind mm_bus_arbiter mmb_arbiter_chk i_mmb_chk (
  .bclk_i       (bclk_i),
  .rst_ni       (rst_ni),
  .prio_ni      (prio_ni),
  .busy_ni      (busy_ni),
  .prio_no      (prio_no),
  .req_no       (req_no),
  .busy_drive_o (busy_drive_o),
  .cbrq_drive_o (cbrq_drive_o),
  .aen_no       (aen_no),
  .lock_s_n     (lock_s_n)
);

// File: tb/test_mm_bus_arbiter.sv
module test_mm_bus_arbiter;
  logic clk, bclk, rst_n;
  logic [2:0] status;
  logic iob_n, res, sel, anyq, lock_n, crql_n, prio_n, busy_n, cbrq_n;
  logic prio_o, req_n, busy_drv, cbrq_drv, aen_n;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  mm_bus_arbiter i_mm_bus_arbiter (
    .clk_i(clk), .bclk_i(bclk), .rst_ni(rst_n), .status_i(status),
    .iobus_mode_ni(iob_n), .resbus_mode_i(res), .sys_sel_i(sel), .any_req_i(anyq),
    .lock_ni(lock_n), .crq_lock_ni(crql_n), .prio_ni(prio_n), .prio_no(prio_o),
    .req_no(req_n), .busy_ni(busy_n), .busy_drive_o(busy_drv), .cbrq_ni(cbrq_n),
    .cbrq_drive_o(cbrq_drv), .aen_no(aen_n)
  );

  // 125 MHz processor clock, bus clock same rate offset by 2 ns
  initial clk = 1'b0;
  always #4 clk = ~clk;
  initial begin
    bclk = 1'b1;
    #2;
    forever #4 bclk = ~bclk;
  end

  // vector: req[20:17] mode{iob_n,res,sel,any}[16:13] status[12:10]
  //         {prio_n,busy_n,cbrq_n,lock_n,crql_n}[9:5] exp{busy,req_n,cbrq,prio_o,aen_n}[4:0]
  localparam int NV = 39;
  localparam logic [20:0] VEC [NV] = '{
    21'b0001_1000_111_01111_01001, // R1 single, idle: no request
    21'b0001_1000_100_01111_10010, // R1 memory: acquire
    21'b0101_1000_111_01111_10010, // R5 idle, nobody asks: keep
    21'b0111_1000_111_01011_01001, // R7 idle with common request: give up
    21'b0001_1000_000_01111_10010, // R1 I/O code also requests
    21'b0110_1000_011_01111_01001, // R6 halt surrenders
    21'b0100_1000_101_00111_00011, // R4 bus busy: keep requesting
    21'b1010_1000_101_10111_00111, // R10 no priority: drive common request
    21'b0100_1000_101_01111_10010, // R4 priority and bus free: own
    21'b0110_1000_101_11111_00111, // R6 priority lost: surrender, re-request
    21'b0100_1000_101_01111_10010, // R4 reacquire
    21'b1001_1000_101_01101_10010, // R9 lock applied
    21'b1001_1000_101_11101_10010, // R9 locked: priority loss ignored
    21'b1001_1000_101_11111_00111, // R9 unlocked: surrender
    21'b1001_1000_101_01110_10010, // R9 common-request lock applied
    21'b1001_1000_111_01010_10010, // R9 common request blocked
    21'b0111_1000_111_01011_01001, // R7 lock removed: give up
    21'b1001_1000_110_01110_10010, // R9 own with common-request lock
    21'b1001_1000_110_11110_00111, // R9 priority loss not blocked
    21'b0100_1000_110_01111_10010, // R4 reacquire
    21'b0101_0000_000_01111_10010, // R5 I/O-bus mode, I/O code: lazy keep
    21'b0010_0000_000_01011_01001, // R2 I/O window + common request
    21'b0010_0000_001_01111_01001, // R2 I/O code not requested
    21'b0010_0000_100_01111_10010, // R2 memory requested
    21'b1000_0000_100_01011_10010, // R8 memory, no window: keep
    21'b1000_0000_101_00011_10010, // R8 code change without any-request: keep
    21'b1000_0001_110_00011_00011, // R8 code change with any-request: give up
    21'b0100_0000_110_01111_10010, // R4 reacquire
    21'b0011_1110_100_01111_10010, // R3 resident, select high: keep
    21'b0011_1100_100_01011_01001, // R3 select low + common request
    21'b0011_1100_100_01111_01001, // R3 select low: no request
    21'b0011_1110_000_01111_10010, // R3 select high, I/O: request
    21'b0010_0110_000_01011_01001, // R2 combined, I/O window
    21'b0011_0110_100_01111_10010, // R3 combined, memory + select
    21'b0011_1000_100_01011_10010, // R3 single ignores select low
    21'b0111_1000_111_01011_01001, // R7 idle give up
    21'b0011_1000_101_01111_10010, // R3 single requests with select low
    21'b1011_1000_111_11111_01011, // R11 idle: priority passes through (1)
    21'b1011_1000_111_01111_01001  // R11 idle: priority passes through (0)
  };

  function automatic logic [4:0] obs();
    return {busy_drv, req_n, cbrq_drv, prio_o, aen_n};
  endfunction

  task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (busy,req_n,cbrq,prio_o,aen_n)", tag, act, exp);
    end
  endtask

  task automatic wait_b(int n);
    repeat (n) @(negedge bclk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b1;
    status = 3'b111; iob_n = 1'b1; res = 1'b0; sel = 1'b0; anyq = 1'b0;
    lock_n = 1'b1; crql_n = 1'b1; prio_n = 1'b0; busy_n = 1'b1; cbrq_n = 1'b1;
    #1 rst_n = 1'b0;
    wait_b(3);
    chk("R13 in reset", obs(), 5'b01001);
    rst_n = 1'b1;
    wait_b(4);
    chk("R13 after reset", obs(), 5'b01001);

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      {iob_n, res, sel, anyq} = v[16:13];
      status = v[12:10];
      {prio_n, busy_n, cbrq_n, lock_n, crql_n} = v[9:5];
      wait_b(10);
      chk($sformatf("R%0d vector %0d", v[20:17], i), obs(), v[4:0]);
    end

    // R12: address enable edges
    status = 3'b100;
    begin
      int k = 0;
      while (busy_drv !== 1'b1 && k < 20) begin
        wait_b(1);
        k++;
      end
    end
    chk("R12 aen low at acquire", {4'b0, aen_n}, 5'b00000);
    prio_n = 1'b1;
    wait_b(1);
    chk("R12 ownership lost", {4'b0, busy_drv}, 5'b00000);
    chk("R12 aen held until processor edge", {4'b0, aen_n}, 5'b00000);
    #6;
    chk("R12 aen released on processor edge", {4'b0, aen_n}, 5'b00001);

    // R13: init while owning
    prio_n = 1'b0;
    wait_b(10);
    chk("R13 owning before init", obs(), 5'b10010);
    rst_n = 1'b0;
    #1;
    chk("R13 init releases bus", obs(), 5'b01001);
    wait_b(2);
    rst_n = 1'b1;
    status = 3'b111;
    wait_b(2);

    finish_run();
  end
endmodule